// File: doc/BRIEF.md
# Serial Bit Destuffer with Stuff-Error Detection

This block sits between a bit sampler and a frame decoder on a serial bus that inserts a complementary bit after every run of five equal bits. Each time the sampler strobes a new line bit, the destuffer decides whether the bit carries data or is an inserted stuff bit. Data bits are passed on with a valid flag in the same cycle. Stuff bits are checked and removed. A stuff bit that has the same value as the run before it cannot be a legal stuff bit. In that case the block raises a one-cycle error pulse, because six equal bits in a row are an illegal line pattern.

A small state machine drives the decisions. `ST_EMPTY` means no run history is held, for example after reset, a frame start or while stuffing is off. `ST_COUNT` means a run is being counted. `ST_EXPECT` means the run has reached the limit, so the next strobed bit is a stuff bit.

The transitions are as follows:
- EMPTY→COUNT takes the first bit of a run.
- COUNT→COUNT takes a bit that either extends a run below the limit or starts a new run.
- COUNT→EXPECT takes the bit that completes the run.
- EXPECT→COUNT takes the stuff bit, which is dropped and becomes a run of one with its own value.
- Any state goes to EMPTY on a frame start, or on a strobe while stuffing is disabled.

A frame-start input clears the history. A stuffing-enable input switches the block to plain pass-through.

Top module: `dstf_destuffer`

## Requirements
- R1: On a strobe that carries a data bit, `out_valid` is 1 and `out_bit` equals `line_bit` in that same cycle.
- R2: After five consecutive equal bits counted since the last history clear or the last stuff bit, the next strobed bit is dropped: `out_valid` stays 0 in that strobe cycle (e.g. line 01111101 delivers 0111111 and line 01111100 delivers 0111110).
- R3: A dropped bit whose value is opposite to the run gives `stuff_err` = 0. A dropped bit equal to the run gives `stuff_err` = 1 for exactly that strobe cycle.
- R4: A dropped stuff bit starts a new run of length one with its own value, so four further equal bits complete the next run of five.
- R5: A stream with no run of five, such as 1010101001, is delivered unchanged with no error.
- R6: While `stuff_en` is 0, every strobed bit is forwarded and `stuff_err` stays 0. The run history is cleared, so after re-enable counting starts from zero.
- R7: `frame_start` clears the run history. A bit strobed in the same cycle as `frame_start` is the first bit of a new run.
- R8: With `bit_stb` at 0, `out_valid`, `out_bit` and `stuff_err` are all 0.
- R9: Reset (asynchronous, active low) empties the run history. After reset, five equal bits are forwarded before a stuff bit is expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe: a new sampled line bit is present |
| line_bit | input | 1 | Sampled line bit, valid while `bit_stb` is 1 |
| stuff_en | input | 1 | 1 = remove and check stuff bits, 0 = pass every bit through |
| frame_start | input | 1 | Clears run history; a bit strobed in the same cycle starts a new run |
| out_valid | output | 1 | A data bit is forwarded this cycle |
| out_bit | output | 1 | Forwarded data bit (0 when `out_valid` is 0) |
| stuff_err | output | 1 | One-cycle pulse: the dropped stuff bit matched the run value |

## Verification
The bound assertions check the properties that hold on every cycle:
- Outputs only ever appear under a strobe.
- A stuff error never coincides with a forwarded bit.
- Pass-through is complete while stuffing is off.
- The run counter never passes the limit, and `ST_EXPECT` is only reached at the limit.
- A dropped bit or a strobed frame start leaves a run of exactly one.

Whether the right bit is dropped depends on the history of whole sequences. Only the bench scenarios can show this: the two seven-bit delivery examples, the alternating stream, a same-polarity violation followed by a reseeded run, re-enable after pass-through, a mid-run frame start and a mid-run reset.

// File: rtl/dstf_pkg.sv
package dstf_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,   // no run history held
        ST_COUNT  = 2'd1,   // counting a run below the limit
        ST_EXPECT = 2'd2    // run at limit, next strobed bit is a stuff bit
    } dstf_state_e;

    // Commands from controller to run tracker
    typedef enum logic [1:0] {
        TRK_HOLD  = 2'd0,
        TRK_CLEAR = 2'd1,
        TRK_SEED  = 2'd2,   // run of one with the current bit's value
        TRK_BUMP  = 2'd3    // extend the run by one
    } dstf_trk_op_e;

endpackage

// File: rtl/dstf_run_tracker.sv
module dstf_run_tracker
    import dstf_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int CNT_W = $clog2(RUN_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dstf_trk_op_e     op,
    input  logic             bit_in,
    output logic [CNT_W-1:0] run_cnt,
    output logic             run_pol,
    output logic             same_pol,
    output logic             full_next
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_pol <= 1'b0;
        end else begin
            unique case (op)
                TRK_HOLD: begin
                end
                TRK_CLEAR: begin
                    run_cnt <= '0;
                    run_pol <= 1'b0;
                end
                TRK_SEED: begin
                    run_cnt <= CNT_ONE;
                    run_pol <= bit_in;
                end
                TRK_BUMP: begin
                    if (run_cnt != CNT_MAX) begin
                        run_cnt <= run_cnt + CNT_ONE;
                    end
                end
            endcase
        end
    end

    assign same_pol  = (bit_in == run_pol);
    assign full_next = same_pol && (run_cnt == CNT_LAST);

endmodule

// File: rtl/dstf_ctrl.sv
module dstf_ctrl
    import dstf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_stb,
    input  logic         stuff_en,
    input  logic         frame_start,
    input  logic         same_pol,
    input  logic         full_next,
    output dstf_state_e  state,
    output dstf_trk_op_e trk_op,
    output logic         fwd,
    output logic         err
);

    dstf_state_e state_nxt;
    dstf_state_e eff_state;

    // A frame start makes the current strobe the first of a new frame
    assign eff_state = frame_start ? ST_EMPTY : state;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = eff_state;
        if (bit_stb) begin
            if (!stuff_en) begin
                state_nxt = ST_EMPTY;
            end else begin
                unique case (eff_state)
                    ST_EMPTY:  state_nxt = ST_COUNT;
                    ST_COUNT:  state_nxt = full_next ? ST_EXPECT : ST_COUNT;
                    ST_EXPECT: state_nxt = ST_COUNT;
                    default:   state_nxt = ST_EMPTY;
                endcase
            end
        end
    end

    // Outputs and tracker command
    always_comb begin
        fwd    = 1'b0;
        err    = 1'b0;
        trk_op = frame_start ? TRK_CLEAR : TRK_HOLD;
        if (bit_stb) begin
            if (!stuff_en) begin
                fwd    = 1'b1;
                trk_op = TRK_CLEAR;
            end else begin
                unique case (eff_state)
                    ST_EMPTY: begin
                        fwd    = 1'b1;
                        trk_op = TRK_SEED;
                    end
                    ST_COUNT: begin
                        fwd    = 1'b1;
                        trk_op = same_pol ? TRK_BUMP : TRK_SEED;
                    end
                    ST_EXPECT: begin
                        err    = same_pol;
                        trk_op = TRK_SEED;
                    end
                    default: begin
                        trk_op = TRK_CLEAR;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dstf_destuffer.sv
module dstf_destuffer
    import dstf_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic line_bit,
    input  logic stuff_en,
    input  logic frame_start,
    output logic out_valid,
    output logic out_bit,
    output logic stuff_err
);

    localparam int CNT_W = $clog2(RUN_LIMIT + 1);

    dstf_state_e      cur_state;
    dstf_trk_op_e     trk_op;
    logic [CNT_W-1:0] run_cnt;
    logic             run_pol;
    logic             same_pol;
    logic             full_next;
    logic             fwd;
    logic             err;

    dstf_run_tracker #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (trk_op),
        .bit_in    (line_bit),
        .run_cnt   (run_cnt),
        .run_pol   (run_pol),
        .same_pol  (same_pol),
        .full_next (full_next)
    );

    dstf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .stuff_en    (stuff_en),
        .frame_start (frame_start),
        .same_pol    (same_pol),
        .full_next   (full_next),
        .state       (cur_state),
        .trk_op      (trk_op),
        .fwd         (fwd),
        .err         (err)
    );

    assign out_valid = fwd;
    assign out_bit   = fwd & line_bit;
    assign stuff_err = err;

endmodule

// File: rtl/dstf_checker.sv
module dstf_checker
    import dstf_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    localparam int CNT_W = $clog2(RUN_LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_stb,
    input logic             line_bit,
    input logic             stuff_en,
    input logic             frame_start,
    input logic             out_valid,
    input logic             out_bit,
    input logic             stuff_err,
    input dstf_state_e      cur_state,
    input logic [CNT_W-1:0] run_cnt
);

    p_valid_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> bit_stb);

    p_err_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> bit_stb);

    p_bit_follows_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == line_bit));

    p_err_drops_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> !out_valid);

    p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !stuff_en) |-> (out_valid && !stuff_err));

    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_W'(RUN_LIMIT));

    p_expect_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_EXPECT) |-> (run_cnt == CNT_W'(RUN_LIMIT)));

    p_stuff_seeds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && stuff_en && !out_valid) |=> (run_cnt == CNT_W'(1)));

    p_frame_start_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && bit_stb && stuff_en) |=> (run_cnt == CNT_W'(1)));

endmodule

bind dstf_destuffer dstf_checker #(
    .RUN_LIMIT (RUN_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .line_bit    (line_bit),
    .stuff_en    (stuff_en),
    .frame_start (frame_start),
    .out_valid   (out_valid),
    .out_bit     (out_bit),
    .stuff_err   (stuff_err),
    .cur_state   (cur_state),
    .run_cnt     (run_cnt)
);

// File: tb/tb_dstf_destuffer.sv
`timescale 1ns/1ps
module tb_dstf_destuffer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic line_bit = 1'b0;
    logic stuff_en = 1'b1;
    logic frame_start = 1'b0;
    logic out_valid, out_bit, stuff_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dstf_destuffer dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_bit(line_bit),
        .stuff_en(stuff_en), .frame_start(frame_start),
        .out_valid(out_valid), .out_bit(out_bit), .stuff_err(stuff_err)
    );

    // Entry bits: [5] frame_start [4] stuff_en [3] line_bit
    //             [2] exp out_valid [1] exp out_bit [0] exp stuff_err
    localparam int NV = 60;
    localparam logic [5:0] VEC [NV] = '{
        // 0..7: line 01111101 -> 0111111
        6'b110_100, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110,
        6'b010_000, 6'b011_110,
        // 8..15: line 01111100 -> 0111110
        6'b110_100, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110,
        6'b010_000, 6'b010_100,
        // 16..26: six ones -> error, then reseeded run of one plus four
        6'b111_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_001,
        6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b010_000,
        // 27..36: 1010101001 unchanged
        6'b111_110, 6'b010_100, 6'b011_110, 6'b010_100, 6'b011_110,
        6'b010_100, 6'b011_110, 6'b010_100, 6'b010_100, 6'b011_110,
        // 37..49: disabled seven ones, then enabled count starts fresh
        6'b101_110, 6'b001_110, 6'b001_110, 6'b001_110, 6'b001_110, 6'b001_110,
        6'b001_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110, 6'b011_110,
        6'b011_001,
        // 50..59: frame start mid-run restarts the count
        6'b110_100, 6'b010_100, 6'b010_100, 6'b010_100, 6'b110_100,
        6'b010_100, 6'b010_100, 6'b010_100, 6'b010_100, 6'b011_000
    };

    function automatic string tag_of(int i);
        if (i < 16) return "R2";
        if (i < 27) return "R3 R4";
        if (i < 37) return "R5";
        if (i < 50) return "R6";
        return "R7";
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Drive one strobe at the falling edge, sample mid-cycle, then one idle cycle
    task automatic apply(input logic fs, input logic en, input logic b,
                         input logic ev, input logic eb, input logic ee,
                         input string tag);
        @(negedge clk);
        frame_start = fs; stuff_en = en; line_bit = b; bit_stb = 1'b1;
        #5;
        check({out_valid, out_bit} == {ev, eb}, {"R1/", tag}, "valid,bit",
              {1'b0, out_valid, out_bit}, {1'b0, ev, eb});
        check(stuff_err == ee, tag, "stuff_err",
              {2'b0, stuff_err}, {2'b0, ee});
        @(negedge clk);
        bit_stb = 1'b0; frame_start = 1'b0; line_bit = ~b;
        #5;
        check({out_valid, out_bit, stuff_err} == 3'b000, "R8", "idle outputs",
              {out_valid, out_bit, stuff_err}, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state, outputs quiet
        repeat (3) @(negedge clk);
        #5;
        check({out_valid, out_bit, stuff_err} == 3'b000, "R9", "reset outputs",
              {out_valid, out_bit, stuff_err}, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][5], VEC[i][4], VEC[i][3],
                  VEC[i][2], VEC[i][1], VEC[i][0], tag_of(i));
        end

        // R9: reset mid-run clears history (no frame start used)
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        end
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");

        // R8: no strobe while line toggles and frame_start pulses
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            line_bit = k[0];
            frame_start = k[1];
            #5;
            check({out_valid, out_bit, stuff_err} == 3'b000, "R8", "no strobe",
                  {out_valid, out_bit, stuff_err}, 3'b000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule